// File: doc/BRIEF.md
# Serial-Load Four-Value Ascending Sorter

This block takes four unsigned 8-bit values over a single input port, one value per accepted beat. It then puts them in ascending order by reusing one compare-and-exchange unit across several clock cycles. Each cycle it examines one adjacent pair of internal slots and swaps the pair only when the lower slot holds the strictly larger value. The fixed pair order is (0,1), (1,2), (2,3), (0,1), (1,2), (0,1). This is a complete bubble sort, so the final slot contents equal those of a bubble sort over the same four values.

A producer presents the values with a valid strobe. Idle cycles between values are allowed. The four slots drive the output bus directly, so the intermediate states of the sort can be seen there. A flag goes high once the slots hold the final ordering. The flag stays high, and the outputs stay frozen, until a reset arrives or a new value is presented, which starts the next job. All registers use a synchronous, active-high reset.

Top module: `seq_sorter`

## Requirements
- R1: When `rst` is high at a rising clock edge, all four slots become 0 and `done` becomes 0. The block then waits for the first value of a new job.
- R2: Slot i appears on `out_data[8*i+7:8*i]`. Accepted values fill slots 0, 1, 2, 3 in arrival order. In the cycle after the fourth value is taken, the outputs show the four values unsorted, in arrival order.
- R3: While a job is being loaded, a cycle with `in_valid` low writes nothing and does not advance the fill position.
- R4: The six clock edges after the fourth value each perform exactly one compare-exchange, on slot pairs (0,1), (1,2), (2,3), (0,1), (1,2), (0,1) in that order. At most two slots change per cycle.
- R5: A pair is swapped only when its lower slot is strictly greater than its upper slot, so equal values are never exchanged. The final contents are ascending from slot 0 to slot 3.
- R6: `done` rises on the edge that performs the sixth exchange, six edges after the edge that accepted the fourth value. It is never high before that edge.
- R7: While `done` is high and `in_valid` is low, `done` stays high and the outputs do not change.
- R8: `in_valid` and `in_data` are ignored during the six exchange cycles.
- R9: `in_valid` high while `done` is high starts a new job. That value is written to slot 0, `done` falls on the same edge, and loading continues at slot 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 8 | Value presented for loading |
| in_valid | input | 1 | Strobe qualifying `in_data` |
| out_data | output | 32 | Slot contents, slot i at bits 8*i+7 down to 8*i |
| done | output | 1 | High when the slots hold the final ascending order |

## Verification
The slots drive the outputs directly. A bad fill position therefore shows up on the very next edge as a value in the wrong lane. A wrong pair choice or comparison shows up at the exchange edge where it happens, because the bench compares the bus against an arithmetic bubble model after every exchange, not only at the end. A step counter that is off by one moves the rising edge of `done` by a cycle, and the bench checks for `done` in every one of the six exchange cycles. A fill counter that advances on idle cycles mixes up the lanes in the unsorted snapshot that follows loading.

// File: rtl/sorter_pkg.sv
package sorter_pkg;

  typedef enum logic [1:0] {
    PH_LOAD = 2'd0,
    PH_SORT = 2'd1,
    PH_DONE = 2'd2
  } sort_phase_t;

  // Lower slot index of the pair examined at exchange step k of an
  // n-element bubble pass schedule (pass p covers pairs 0 .. n-2-p).
  function automatic int unsigned step_lo(input int unsigned n, input int unsigned k);
    int unsigned c;
    int unsigned r;
    c = 0;
    r = 0;
    for (int unsigned p = 0; p + 1 < n; p++) begin
      for (int unsigned j = 0; j + 1 + p < n; j++) begin
        if (c == k) r = j;
        c++;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/sorter_cx.sv
module sorter_cx #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         swap,
  output logic [W-1:0] lo_val,
  output logic [W-1:0] hi_val
);
  // Strict comparison: equal operands stay in place.
  always_comb begin
    swap   = a > b;
    lo_val = swap ? b : a;
    hi_val = swap ? a : b;
  end
endmodule

// File: rtl/sorter_ctrl.sv
module sorter_ctrl
  import sorter_pkg::*;
#(
  parameter int N = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  wr_en,
  output logic [$clog2(N)-1:0]  wr_idx,
  output logic                  cx_en,
  output logic [$clog2(N)-1:0]  cx_lo,
  output logic                  done
);
  localparam int IW = $clog2(N);
  localparam int S  = N * (N - 1) / 2;
  localparam int SW = (S > 1) ? $clog2(S) : 1;

  sort_phase_t   ph;
  logic [IW-1:0] fill;
  logic [SW-1:0] step;

  always_comb begin
    wr_en  = in_valid && (ph == PH_LOAD || ph == PH_DONE);
    wr_idx = (ph == PH_DONE) ? '0 : fill;
    cx_en  = (ph == PH_SORT);
    cx_lo  = IW'(step_lo(N, int'(step)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= PH_LOAD;
      fill <= '0;
      step <= '0;
      done <= 1'b0;
    end else begin
      case (ph)
        PH_LOAD: begin
          if (in_valid) begin
            if (fill == IW'(N - 1)) begin
              ph   <= PH_SORT;
              fill <= '0;
              step <= '0;
            end else begin
              fill <= fill + 1'b1;
            end
          end
        end
        PH_SORT: begin
          if (step == SW'(S - 1)) begin
            ph   <= PH_DONE;
            step <= '0;
            done <= 1'b1;
          end else begin
            step <= step + 1'b1;
          end
        end
        PH_DONE: begin
          if (in_valid) begin
            ph   <= PH_LOAD;
            fill <= IW'(1);
            done <= 1'b0;
          end
        end
        default: begin
          ph   <= PH_LOAD;
          fill <= '0;
          step <= '0;
          done <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/sorter_regs.sv
module sorter_regs #(
  parameter int W = 8,
  parameter int N = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [$clog2(N)-1:0]  wr_idx,
  input  logic [W-1:0]          wr_data,
  input  logic                  cx_en,
  input  logic [$clog2(N)-1:0]  cx_lo,
  output logic [N*W-1:0]        slots_flat
);
  localparam int IW = $clog2(N);

  logic [W-1:0]  slot [N];
  logic [IW-1:0] cx_hi;
  logic [W-1:0]  op_a, op_b, min_v, max_v;
  logic          do_swap;

  always_comb begin
    cx_hi = cx_lo + 1'b1;
    op_a  = slot[cx_lo];
    op_b  = slot[cx_hi];
  end

  sorter_cx #(.W(W)) u_cx (
    .a      (op_a),
    .b      (op_b),
    .swap   (do_swap),
    .lo_val (min_v),
    .hi_val (max_v)
  );

  for (genvar i = 0; i < N; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        slot[i] <= '0;
      end else if (wr_en) begin
        if (wr_idx == IW'(i)) slot[i] <= wr_data;
      end else if (cx_en && do_swap) begin
        if (cx_lo == IW'(i))      slot[i] <= min_v;
        else if (cx_hi == IW'(i)) slot[i] <= max_v;
      end
    end
    assign slots_flat[i*W +: W] = slot[i];
  end
endmodule

// File: rtl/seq_sorter.sv
module seq_sorter #(
  parameter int W = 8,
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   in_data,
  input  logic           in_valid,
  output logic [N*W-1:0] out_data,
  output logic           done
);
  localparam int IW = $clog2(N);

  logic          wr_en, cx_en;
  logic [IW-1:0] wr_idx, cx_lo;

  sorter_ctrl #(.N(N)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .cx_en    (cx_en),
    .cx_lo    (cx_lo),
    .done     (done)
  );

  sorter_regs #(.W(W), .N(N)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (in_data),
    .cx_en      (cx_en),
    .cx_lo      (cx_lo),
    .slots_flat (out_data)
  );
endmodule

// File: rtl/sorter_chk.sv
module sorter_chk #(
  parameter int W = 8,
  parameter int N = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [N*W-1:0] out_data,
  input logic           done
);
  logic [N*W-1:0] prev_out;
  logic           have_prev;
  logic [N-1:0]   chg;
  logic           ascending;

  always_ff @(posedge clk) begin
    prev_out  <= out_data;
    have_prev <= !rst;
  end

  for (genvar i = 0; i < N; i++) begin : g_chg
    assign chg[i] = out_data[i*W +: W] != prev_out[i*W +: W];
  end

  always_comb begin
    ascending = 1'b1;
    for (int i = 0; i + 1 < N; i++)
      if (out_data[i*W +: W] > out_data[(i+1)*W +: W]) ascending = 1'b0;
  end

  AST_ONE_EXCHANGE: assert property (@(posedge clk) disable iff (rst)
    have_prev |-> $countones(chg) <= 2); // R4

  AST_DONE_ORDERED: assert property (@(posedge clk) disable iff (rst)
    done |-> ascending); // R5

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done && !in_valid) |=> (done && $stable(out_data))); // R7

  AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (done && in_valid) |=> !done); // R9
endmodule

bind seq_sorter sorter_chk #(.W(W), .N(N)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .out_data (out_data),
  .done     (done)
);

// File: tb/sim_seq_sorter.sv
module sim_seq_sorter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  in_data = '0;
  logic        in_valid = 1'b0;
  logic [31:0] out_data;
  logic        done;

  int nchk = 0;
  int nerr = 0;
  int sched [6];

  always #4 clk = ~clk;

  seq_sorter u0 (
    .clk      (clk),
    .rst      (rst),
    .in_data  (in_data),
    .in_valid (in_valid),
    .out_data (out_data),
    .done     (done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pack4(input logic [3:0][7:0] v);
    return {v[3], v[2], v[1], v[0]};
  endfunction

  // One job: load v (optionally with idle gaps), then follow six exchanges.
  task automatic run_job(input logic [3:0][7:0] v, input bit gap, input bit noise, input bit hold);
    logic [3:0][7:0] cur;
    logic [7:0] t;
    int lo;
    cur = v;
    @(negedge clk);
    in_valid = 1'b1; in_data = v[0];
    for (int i = 1; i < 4; i++) begin
      @(negedge clk);
      if (i == 1) begin
        chk("R9 done low after first value", {31'd0, done}, 32'd0);
        chk("R2 slot0 written first", {24'd0, out_data[7:0]}, {24'd0, v[0]});
      end
      if (gap) begin
        in_valid = 1'b0; in_data = 8'hA5;
        repeat (2) @(negedge clk);
      end
      in_valid = 1'b1; in_data = v[i];
    end
    @(negedge clk);
    chk(gap ? "R3 load with gaps" : "R2 unsorted snapshot", out_data, pack4(v));
    in_valid = noise; in_data = 8'h5A;
    for (int k = 0; k < 6; k++) begin
      lo = sched[k];
      if (cur[lo] > cur[lo+1]) begin
        t = cur[lo]; cur[lo] = cur[lo+1]; cur[lo+1] = t;
      end
      @(negedge clk);
      chk(noise ? "R8 exchange step with noise" : "R4 exchange step", out_data, pack4(cur));
      chk("R6 done timing", {31'd0, done}, {31'd0, k == 5});
      in_valid = (k < 5) ? noise : 1'b0;
      in_data  = 8'(k * 37 + 11);
    end
    for (int i = 0; i < 3; i++)
      if (out_data[i*8 +: 8] > out_data[(i+1)*8 +: 8])
        chk("R5 ascending", out_data, pack4(cur) ^ 32'hFFFF_FFFF);
    nchk++;
    if (hold) begin
      repeat (3) @(negedge clk);
      chk("R7 hold value", out_data, pack4(cur));
      chk("R7 hold done", {31'd0, done}, 32'd1);
    end
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin : main
    logic [3:0][7:0] v;
    int idx;
    begin
      int c;
      c = 0;
      for (int p = 0; p < 3; p++)
        for (int j = 0; j + 1 + p < 4; j++) begin
          sched[c] = j;
          c++;
        end
    end
    repeat (3) @(negedge clk);
    chk("R1 reset slots", out_data, 32'd0);
    chk("R1 reset done", {31'd0, done}, 32'd0);
    rst = 1'b0;

    // First job from the reset state, with gaps.
    v = {8'd3, 8'd200, 8'd0, 8'd255};
    run_job(v, 1'b1, 1'b0, 1'b1);

    // Reset in the middle of a sort.
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'd9;
    repeat (4) @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-sort reset slots", out_data, 32'd0);
    chk("R1 mid-sort reset done", {31'd0, done}, 32'd0);
    rst = 1'b0;

    // Sweep of all tuples over four lane values, including equal values.
    idx = 0;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          for (int d = 0; d < 4; d++) begin
            v = {8'(d * 85), 8'(c * 85), 8'(b * 85), 8'(a * 85)};
            run_job(v, (idx % 17) == 3, (idx % 5) == 1, (idx % 31) == 7);
            idx++;
          end

    v = {8'd1, 8'd2, 8'd3, 8'd4};
    run_job(v, 1'b0, 1'b1, 1'b1);
    v = {8'd128, 8'd127, 8'd128, 8'd127};
    run_job(v, 1'b0, 1'b0, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule